// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps the directory entry for one memory word that several processors, each with a private cache, may hold copies of. The entry records whether the word is cached by nobody, shared read-only by one or more caches with memory up to date, or held by a single writer whose copy makes memory stale. A presence vector records which caches hold a copy. The controller also owns the memory word itself.

Caches send read-miss, write-miss and eviction requests tagged with the requester number. The controller takes one request at a time over a valid/ready handshake. If no other cache has to act, it finishes the request at once. Otherwise it sends invalidate or fetch commands to the other caches, stays busy until every one of them has acknowledged, and then updates the entry, writes back to memory if needed, and returns reply data to the requester.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset the entry is uncached (`dir_state` = 2'b00, where 2'b01 is shared and 2'b10 is exclusive) with `sharers` all zero, `mem_value` equals `MEM_INIT`, `req_ready` is high and `busy` is low.
- R2: A read miss (`req_op` = 2'b00) to an uncached entry replies with the memory value and makes the entry shared, with only the requester's bit set. Bit i of `sharers` is CPU i.
- R3: A read miss to a shared entry replies with the memory value, leaves memory unchanged and adds the requester's bit to the existing sharers.
- R4: A read miss to an exclusive entry owned by another CPU raises `fetch_req` for the owner only, with `fetch_inv` low. When the fetch is acknowledged, memory takes `fetch_data` and `mem_wr` pulses. The reply carries that data, and the entry becomes shared with both the owner and the requester bits set.
- R5: A write miss (`req_op` = 2'b01) to a shared entry raises `inv_req` for every sharer except the writer. After all of them have acknowledged, the entry becomes exclusive with only the writer's bit set and memory is unchanged. If the writer is the only sharer, no invalidate is sent and the request finishes at once.
- R6: A write miss to an uncached entry replies with the memory value and makes the entry exclusive with only the writer's bit set.
- R7: A write miss to an exclusive entry owned by another CPU raises `fetch_req` for the owner with `fetch_inv` high. Memory takes the fetched data with a `mem_wr` pulse, and ownership passes to the writer alone.
- R8: An eviction (`req_op` = 2'b10) from the exclusive owner writes `req_data` to memory with a `mem_wr` pulse and returns the entry to uncached with all-zero sharers. An eviction from any CPU that is not the exclusive owner leaves the state, the sharers and memory unchanged.
- R9: `busy` is high, and `req_ready` is low, exactly while commands are outstanding. Each `inv_req` or `fetch_req` bit stays high until its acknowledge is seen. The request does not finish until every outstanding acknowledge has arrived, in any order or cycle. The state does not change while busy.
- R10: A request that needs no command finishes on its acceptance edge. `rsp_valid` is high for one cycle, with `rsp_id` equal to the requester, in the cycle after acceptance or after the last acknowledge.
- R11: An exclusive entry has exactly one sharer bit set, an uncached entry has none, and a shared entry has at least one.
- R12: `mem_value` changes only in the cycle in which `mem_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_op | input | 2 | 00 read miss, 01 write miss, 10 eviction |
| req_id | input | IDW | Requesting CPU number |
| req_data | input | DW | Write-back data for an eviction |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_id | output | IDW | CPU the reply belongs to |
| rsp_data | output | DW | Reply data |
| inv_req | output | NCPU | Per-CPU invalidate command |
| inv_ack | input | NCPU | Per-CPU invalidate acknowledge |
| fetch_req | output | NCPU | Per-CPU fetch command to the owner |
| fetch_inv | output | 1 | Owner must also drop its copy |
| fetch_ack | input | NCPU | Per-CPU fetch acknowledge |
| fetch_data | input | DW | Data returned with a fetch acknowledge |
| mem_wr | output | 1 | Memory was updated this cycle |
| mem_value | output | DW | Current memory word |
| busy | output | 1 | Commands outstanding |
| dir_state | output | 2 | Entry state |
| sharers | output | NCPU | Presence vector, bit i is CPU i |

## Verification
The bench walks the entry through a fixed sequence: uncached, shared, exclusive, shared again, all three CPUs sharing, and exclusive under a new owner. It checks the state, the vector and memory at every step. The invalidate acknowledges are returned one at a time, so a controller that finished on the first acknowledge would show itself by dropping busy early. A write by the only sharer must finish without commands; a design that invalidated the writer itself would hang or lose the line. It also covers an eviction from a non-owner, which a careless design would let wipe the owner's line, and a fetch from one owner to another, where forgetting the write-back would leave memory stale.

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl #(
  parameter int NCPU = 3,
  parameter int DW = 8,
  parameter int unsigned MEM_INIT = 4,
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [IDW-1:0]  req_id,
  input  logic [DW-1:0]   req_data,
  output logic            rsp_valid,
  output logic [IDW-1:0]  rsp_id,
  output logic [DW-1:0]   rsp_data,
  output logic [NCPU-1:0] inv_req,
  input  logic [NCPU-1:0] inv_ack,
  output logic [NCPU-1:0] fetch_req,
  output logic            fetch_inv,
  input  logic [NCPU-1:0] fetch_ack,
  input  logic [DW-1:0]   fetch_data,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_value,
  output logic            busy,
  output logic [1:0]      dir_state,
  output logic [NCPU-1:0] sharers
);
  localparam logic [1:0] ST_U = 2'b00, ST_S = 2'b01, ST_E = 2'b10;
  localparam logic [1:0] OP_RD = 2'b00, OP_WR = 2'b01, OP_EV = 2'b10;

  logic [1:0]      st_q, op_q, st_n;
  logic [NCPU-1:0] vec_q, inv_q, fet_q, vec_n;
  logic [IDW-1:0]  id_q, rid_q;
  logic [DW-1:0]   mem_q, fdat_q, rdat_q, mem_n, rdat_n;
  logic            busy_q, rv_q, mw_q, finv_q, wr_n;

  logic [NCPU-1:0] req_bit, others, inv_new, fet_new, inv_left, fet_left, f_bit;
  logic [1:0]      f_op;
  logic [IDW-1:0]  f_id;
  logic [DW-1:0]   fdat;
  logic            accept, fet_hit, finish, owner_self;

  assign accept   = req_valid && !busy_q;
  assign req_bit  = NCPU'(1) << req_id;
  assign others   = vec_q & ~req_bit;
  assign inv_left = inv_q & ~inv_ack;
  assign fet_left = fet_q & ~fetch_ack;
  assign fet_hit  = |(fet_q & fetch_ack);
  assign fdat     = fet_hit ? fetch_data : fdat_q;

  always_comb begin
    inv_new = '0;
    fet_new = '0;
    if (req_op == OP_RD && st_q == ST_E) fet_new = others;
    if (req_op == OP_WR) begin
      if (st_q == ST_S) inv_new = others;
      if (st_q == ST_E) fet_new = others;
    end
  end

  assign finish = busy_q ? (inv_left == '0 && fet_left == '0)
                         : (accept && inv_new == '0 && fet_new == '0);
  assign f_op = busy_q ? op_q : req_op;
  assign f_id = busy_q ? id_q : req_id;
  assign f_bit = NCPU'(1) << f_id;
  assign owner_self = (st_q == ST_E) && (vec_q == f_bit);

  always_comb begin
    st_n   = st_q;
    vec_n  = vec_q;
    mem_n  = mem_q;
    wr_n   = 1'b0;
    rdat_n = mem_q;
    case (f_op)
      OP_RD: begin
        if (st_q != ST_E) begin
          st_n  = ST_S;
          vec_n = vec_q | f_bit;
        end else if (!owner_self) begin
          st_n   = ST_S;
          vec_n  = vec_q | f_bit;
          mem_n  = fdat;
          wr_n   = 1'b1;
          rdat_n = fdat;
        end
      end
      OP_WR: begin
        st_n  = ST_E;
        vec_n = f_bit;
        if (st_q == ST_E && !owner_self) begin
          mem_n  = fdat;
          wr_n   = 1'b1;
          rdat_n = fdat;
        end
      end
      OP_EV: begin
        if (owner_self) begin
          st_n   = ST_U;
          vec_n  = '0;
          mem_n  = req_data;
          wr_n   = 1'b1;
          rdat_n = req_data;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_U;
      vec_q  <= '0;
      mem_q  <= DW'(MEM_INIT);
      busy_q <= 1'b0;
      inv_q  <= '0;
      fet_q  <= '0;
      fdat_q <= '0;
      op_q   <= OP_RD;
      id_q   <= '0;
      finv_q <= 1'b0;
      rv_q   <= 1'b0;
      mw_q   <= 1'b0;
      rid_q  <= '0;
      rdat_q <= '0;
    end else begin
      rv_q <= 1'b0;
      mw_q <= 1'b0;
      if (accept) begin
        op_q   <= req_op;
        id_q   <= req_id;
        finv_q <= (req_op == OP_WR);
      end
      if (accept && !finish) begin
        busy_q <= 1'b1;
        inv_q  <= inv_new;
        fet_q  <= fet_new;
      end else if (busy_q) begin
        inv_q <= inv_left;
        fet_q <= fet_left;
        if (fet_hit) fdat_q <= fetch_data;
        if (finish) busy_q <= 1'b0;
      end
      if (finish) begin
        st_q   <= st_n;
        vec_q  <= vec_n;
        mem_q  <= mem_n;
        mw_q   <= wr_n;
        rv_q   <= 1'b1;
        rid_q  <= f_id;
        rdat_q <= rdat_n;
      end
    end
  end

  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign inv_req   = inv_q;
  assign fetch_req = fet_q;
  assign fetch_inv = finv_q;
  assign rsp_valid = rv_q;
  assign rsp_id    = rid_q;
  assign rsp_data  = rdat_q;
  assign mem_wr    = mw_q;
  assign mem_value = mem_q;
  assign dir_state = st_q;
  assign sharers   = vec_q;
endmodule

// File: rtl/dir_coherence_ctrl_chk.sv
module dir_coherence_ctrl_chk #(
  parameter int NCPU = 3,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rsp_valid,
  input logic [NCPU-1:0] inv_req,
  input logic [NCPU-1:0] fetch_req,
  input logic            mem_wr,
  input logic [DW-1:0]   mem_value,
  input logic [1:0]      dir_state,
  input logic [NCPU-1:0] sharers
);
  assert_excl_one_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'b10 |-> $countones(sharers) == 1);
  assert_uncached_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'b00 |-> sharers == '0);
  assert_shared_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_state == 2'b01 |-> sharers != '0);
  assert_mem_on_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_value != $past(mem_value) |-> mem_wr);
  assert_cmds_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req != '0 || fetch_req != '0) |-> busy);
  assert_busy_ends_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
  assert_state_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dir_state) && $stable(sharers)));
endmodule

bind dir_coherence_ctrl dir_coherence_ctrl_chk #(.NCPU(NCPU), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .inv_req(inv_req), .fetch_req(fetch_req), .mem_wr(mem_wr),
  .mem_value(mem_value), .dir_state(dir_state), .sharers(sharers)
);

// File: tb/dir_coherence_ctrl_tb_top.sv
module dir_coherence_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'b00;
  logic [1:0] req_id = 2'd0;
  logic [7:0] req_data = 8'd0;
  logic rsp_valid;
  logic [1:0] rsp_id;
  logic [7:0] rsp_data;
  logic [2:0] inv_req, fetch_req;
  logic [2:0] inv_ack = 3'b000, fetch_ack = 3'b000;
  logic fetch_inv;
  logic [7:0] fetch_data = 8'd0;
  logic mem_wr, busy;
  logic [7:0] mem_value;
  logic [1:0] dir_state;
  logic [2:0] sharers;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dir_coherence_ctrl #(.NCPU(3), .DW(8), .MEM_INIT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_id(req_id), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .inv_req(inv_req), .inv_ack(inv_ack), .fetch_req(fetch_req),
    .fetch_inv(fetch_inv), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .mem_wr(mem_wr), .mem_value(mem_value), .busy(busy),
    .dir_state(dir_state), .sharers(sharers)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int id, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_id = 2'(id); req_data = 8'(d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic give_ack(input logic [2:0] im, input logic [2:0] fm, input int fd);
    inv_ack = im; fetch_ack = fm; fetch_data = 8'(fd);
    @(negedge clk);
    inv_ack = 3'b000; fetch_ack = 3'b000;
  endtask

  task automatic t_reset();
    chk("R1 state", dir_state, 0);
    chk("R1 sharers", sharers, 0);
    chk("R1 mem", mem_value, 4);
    chk("R1 ready", req_ready, 1);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_read_uncached();
    issue(2'b00, 2, 0);
    chk("R10 rsp_valid", rsp_valid, 1);
    chk("R10 rsp_id", rsp_id, 2);
    chk("R2 rsp_data", rsp_data, 4);
    chk("R2 state", dir_state, 1);
    chk("R2 sharers", sharers, 3'b100);
    @(negedge clk);
    chk("R10 rsp one cycle", rsp_valid, 0);
  endtask

  task automatic t_write_sole_sharer();
    issue(2'b01, 2, 5);
    chk("R5 sole no busy", busy, 0);
    chk("R5 sole rsp", rsp_valid, 1);
    chk("R5 sole state", dir_state, 2);
    chk("R5 sole sharers", sharers, 3'b100);
    chk("R5 sole mem", mem_value, 4);
  endtask

  task automatic t_read_exclusive();
    issue(2'b00, 1, 0);
    chk("R9 busy", busy, 1);
    chk("R9 ready low", req_ready, 0);
    chk("R4 fetch_req", fetch_req, 3'b100);
    chk("R4 fetch_inv", fetch_inv, 0);
    chk("R4 no rsp yet", rsp_valid, 0);
    @(negedge clk);
    chk("R9 wait ack", busy, 1);
    chk("R9 fetch held", fetch_req, 3'b100);
    give_ack(3'b000, 3'b100, 5);
    chk("R4 rsp_valid", rsp_valid, 1);
    chk("R4 rsp_data", rsp_data, 5);
    chk("R4 rsp_id", rsp_id, 1);
    chk("R4 mem", mem_value, 5);
    chk("R12 mem_wr", mem_wr, 1);
    chk("R4 state", dir_state, 1);
    chk("R4 sharers", sharers, 3'b110);
    chk("R9 idle", busy, 0);
  endtask

  task automatic t_read_shared();
    issue(2'b00, 0, 0);
    chk("R3 rsp_data", rsp_data, 5);
    chk("R3 state", dir_state, 1);
    chk("R3 sharers", sharers, 3'b111);
    chk("R3 no mem_wr", mem_wr, 0);
  endtask

  task automatic t_write_shared();
    issue(2'b01, 1, 9);
    chk("R5 inv_req", inv_req, 3'b101);
    chk("R5 no fetch", fetch_req, 0);
    give_ack(3'b001, 3'b000, 0);
    chk("R9 partial busy", busy, 1);
    chk("R9 partial inv", inv_req, 3'b100);
    chk("R9 partial no rsp", rsp_valid, 0);
    give_ack(3'b100, 3'b000, 0);
    chk("R5 rsp", rsp_valid, 1);
    chk("R5 state", dir_state, 2);
    chk("R5 sharers", sharers, 3'b010);
    chk("R5 mem kept", mem_value, 5);
  endtask

  task automatic t_evict_nonowner();
    issue(2'b10, 0, 77);
    chk("R8 ignore rsp", rsp_valid, 1);
    chk("R8 ignore state", dir_state, 2);
    chk("R8 ignore sharers", sharers, 3'b010);
    chk("R8 ignore mem", mem_value, 5);
  endtask

  task automatic t_write_exclusive_other();
    issue(2'b01, 2, 0);
    chk("R7 fetch_req", fetch_req, 3'b010);
    chk("R7 fetch_inv", fetch_inv, 1);
    give_ack(3'b000, 3'b010, 9);
    chk("R7 rsp_data", rsp_data, 9);
    chk("R7 mem", mem_value, 9);
    chk("R7 state", dir_state, 2);
    chk("R7 sharers", sharers, 3'b100);
  endtask

  task automatic t_evict_owner();
    issue(2'b10, 2, 12);
    chk("R8 mem", mem_value, 12);
    chk("R12 evict mem_wr", mem_wr, 1);
    chk("R8 state", dir_state, 0);
    chk("R8 sharers", sharers, 0);
  endtask

  task automatic t_write_uncached();
    issue(2'b01, 0, 3);
    chk("R6 rsp_data", rsp_data, 12);
    chk("R6 state", dir_state, 2);
    chk("R6 sharers", sharers, 3'b001);
    chk("R6 mem", mem_value, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_uncached();
    t_write_sole_sharer();
    t_read_exclusive();
    t_read_shared();
    t_write_shared();
    t_evict_nonowner();
    t_write_exclusive_other();
    t_evict_owner();
    t_write_uncached();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule